// File: doc/BRIEF.md
# Flash Command Unlock Guard

This block sits beside the register file of a flash controller and decides whether destructive or privileged flash requests may proceed. Software unlocks it by writing a fixed 32-bit value to a dedicated key register. From then on a latched "unlocked" flag lets one protected command through, or lets software write the user configuration register. Protected commands are signature check, page erase, whole-array erase and abort.

The unlock is sticky. Accesses to unrelated registers leave it in place. It ends when a wrong value is written to the key register or when any command is issued. A command clears it whether or not that command was allowed, and so does a command request raised by other logic through a separate strobe. A protected command issued while locked is refused, and a sticky refusal flag records the event until software clears it. Non-protected command codes are always forwarded.

The register bus presents at most one write per cycle: a strobe, a byte address and 32 bits of data. Command decisions appear as one-cycle pulses one clock after the command write. The configuration write enable is combinational, in the same cycle as the write.

Top module: `flash_key_guard`

## Requirements
- R1: After reset the unlocked flag is 0, the refusal flag is 0, no grant, refusal or forward pulse is active, and a configuration write gives no write enable.
- R2: A write of 0x676C7565 to the key address (byte offset 0x20) sets the unlocked flag from the next cycle.
- R3: A write of any other value to the key address clears the unlocked flag from the next cycle.
- R4: Writes to other, non-command addresses and idle cycles leave the unlocked flag unchanged.
- R5: A command write (byte offset 0x24, code in data bits 3:0) with a protected code, while unlocked, pulses grant bit code-1 for one cycle in the next cycle. The codes are 1 signature check, 2 page erase, 3 whole erase and 4 abort.
- R6: A protected command written while locked pulses refusal bit code-1 in the next cycle, gives no grant, and sets the refusal flag in the same cycle.
- R7: Any command write, granted, refused or forwarded, clears the unlocked flag from the next cycle. An external command-request strobe clears it too.
- R8: A command write with a non-protected code (0 or 5 to 15) pulses the forward output with that code in the next cycle, whether locked or unlocked.
- R9: The configuration write enable is high in the cycle of a write to the configuration address (byte offset 0x28) only while the unlocked flag is 1.
- R10: The refusal flag holds until a write to the status address (byte offset 0x2C) with data bit 0 set clears it from the next cycle.
- R11: A command-request strobe in the same cycle as a correct key write leaves the flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| cmd_req_i | input | 1 | Command requested by other logic |
| unlocked_o | output | 1 | Key currently valid |
| grant_o | output | 4 | Per protected command: accepted pulse |
| refuse_o | output | 4 | Per protected command: rejected pulse |
| fwd_o | output | 1 | Non-protected command forwarded pulse |
| fwd_code_o | output | 4 | Code of forwarded command (0 when idle) |
| refused_flag_o | output | 1 | Sticky command-refused status |
| cfg_we_o | output | 1 | Configuration register write enable |

## Verification
The assertions assume that the bus offers one write per cycle, so a key write, a command write and a status write never land together. They also assume that the only outside path to the key is the command-request strobe, which may coincide with any write. The stimulus uses a single bus-write task that takes one address per cycle. It drives the request strobe on its own, including on the same cycle as unlock writes. A pseudo-random phase puts extra weight on key, command and status addresses so that unlock, refusal and clear sequences overlap.

// File: rtl/fkg_pkg.sv
// Package: shared constants and helpers for the flash unlock guard.
// Assumes command codes are CODE_W bits wide with protected codes 1..NPROT.
package fkg_pkg;
    localparam int CODE_W = 4;
    localparam int NPROT  = 4;

    typedef enum logic [CODE_W-1:0] {
        CODE_NOP       = 4'd0,
        CODE_SIGN      = 4'd1,
        CODE_ERASE_PG  = 4'd2,
        CODE_ERASE_ALL = 4'd3,
        CODE_ABORT     = 4'd4
    } cmd_code_e;

    // True when the code names a command that needs the key.
    function automatic logic is_protected(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(1)) && (c <= CODE_W'(NPROT));
    endfunction
endpackage

// File: rtl/fkg_key.sv
// Module: holds the sticky unlocked flag.
// Assumes key_wr_i and clear_i come from a single-write-per-cycle bus decode;
// a clear always wins over a key write in the same cycle.
module fkg_key #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] UNLOCK = 32'h676C7565
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    input  logic              clear_i,
    output logic              unlocked_o
);
    logic match;
    assign match = (key_data_i == DATA_W'(UNLOCK));

    // Update the flag: clear on command, else follow a key write.
    always_ff @(posedge clk) begin
        if (!rst_n)        unlocked_o <= 1'b0;
        else if (clear_i)  unlocked_o <= 1'b0;
        else if (key_wr_i) unlocked_o <= match;
    end

    // R2
    key_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(key_wr_i && match && !clear_i));
    // R3
    key_wrong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_i && !match) |=> !unlocked_o);
    // R7
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !unlocked_o);
    // R4
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr_i && !clear_i) |=> $stable(unlocked_o));
endmodule

// File: rtl/fkg_cmd.sv
// Module: judges each command write against the unlocked flag and keeps
// the sticky refusal status. Outputs are registered one-cycle pulses.
// Assumes cmd_wr_i and stat_clr_i are never high together.
module fkg_cmd
    import fkg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              unlocked_i,
    input  logic              stat_clr_i,
    output logic [NPROT-1:0]  grant_o,
    output logic [NPROT-1:0]  refuse_o,
    output logic              fwd_o,
    output logic [CODE_W-1:0] fwd_code_o,
    output logic              refused_flag_o
);
    logic prot;
    logic [NPROT-1:0] grant_d, refuse_d;
    assign prot = is_protected(code_i);

    // One grant and one refusal lane per protected command code.
    for (genvar i = 0; i < NPROT; i++) begin : g_lane
        logic hit;
        assign hit         = cmd_wr_i && (code_i == CODE_W'(i + 1));
        assign grant_d[i]  = hit && unlocked_i;
        assign refuse_d[i] = hit && !unlocked_i;
    end

    // Register the decision pulses and forwarded code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o    <= '0;
            refuse_o   <= '0;
            fwd_o      <= 1'b0;
            fwd_code_o <= '0;
        end else begin
            grant_o    <= grant_d;
            refuse_o   <= refuse_d;
            fwd_o      <= cmd_wr_i && !prot;
            fwd_code_o <= (cmd_wr_i && !prot) ? code_i : '0;
        end
    end

    // Sticky refusal status: set on refusal, cleared by status write.
    always_ff @(posedge clk) begin
        if (!rst_n)            refused_flag_o <= 1'b0;
        else if (|refuse_d)    refused_flag_o <= 1'b1;
        else if (stat_clr_i)   refused_flag_o <= 1'b0;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && $onehot0(refuse_o));
    // R6
    grant_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & refuse_o) == '0);
    // R5
    grant_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> $past(unlocked_i && cmd_wr_i));
    // R6
    refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse_o != '0) |-> refused_flag_o);
    // R8
    fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> (grant_o == '0 && refuse_o == '0));
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refused_flag_o && !stat_clr_i) |=> refused_flag_o);
endmodule

// File: rtl/flash_key_guard.sv
// Module: top of the flash unlock guard. Decodes the register bus into key,
// command, configuration and status writes and wires the key holder and the
// command judge. Assumes one bus write per cycle at byte addresses.
module flash_key_guard
    import fkg_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] UNLOCK    = 32'h676C7565,
    parameter logic [7:0]  KEY_ADDR  = 8'h20,
    parameter logic [7:0]  CMD_ADDR  = 8'h24,
    parameter logic [7:0]  CFG_ADDR  = 8'h28,
    parameter logic [7:0]  STAT_ADDR = 8'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              cmd_req_i,
    output logic              unlocked_o,
    output logic [NPROT-1:0]  grant_o,
    output logic [NPROT-1:0]  refuse_o,
    output logic              fwd_o,
    output logic [CODE_W-1:0] fwd_code_o,
    output logic              refused_flag_o,
    output logic              cfg_we_o
);
    logic key_wr, cmd_wr, cfg_wr, stat_clr;

    // Address decode of the single write per cycle.
    always_comb begin
        key_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(KEY_ADDR));
        cmd_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(CMD_ADDR));
        cfg_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(CFG_ADDR));
        stat_clr = bus_wr_i && (bus_addr_i == ADDR_W'(STAT_ADDR)) && bus_wdata_i[0];
    end

    assign cfg_we_o = cfg_wr && unlocked_o;

    fkg_key #(.DATA_W(DATA_W), .UNLOCK(UNLOCK)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr),
        .key_data_i (bus_wdata_i),
        .clear_i    (cmd_wr || cmd_req_i),
        .unlocked_o (unlocked_o)
    );

    fkg_cmd u_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_wr_i       (cmd_wr),
        .code_i         (bus_wdata_i[CODE_W-1:0]),
        .unlocked_i     (unlocked_o),
        .stat_clr_i     (stat_clr),
        .grant_o        (grant_o),
        .refuse_o       (refuse_o),
        .fwd_o          (fwd_o),
        .fwd_code_o     (fwd_code_o),
        .refused_flag_o (refused_flag_o)
    );

    // R7
    cmd_clears_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_W'(CMD_ADDR)) |=> !unlocked_o);
    // R11
    req_beats_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_i && bus_wr_i && bus_addr_i == ADDR_W'(KEY_ADDR)) |=> !unlocked_o);
endmodule

// File: tb/test_flash_key_guard.sv
module test_flash_key_guard;
    localparam logic [31:0] KEYV = 32'h676C7565;
    localparam logic [7:0] A_KEY = 8'h20, A_CMD = 8'h24, A_CFG = 8'h28, A_STAT = 8'h2C;

    logic clk = 0, rst_n = 0, wr = 0, req = 0;
    logic [7:0] addr = 0;
    logic [31:0] wdata = 0;
    logic unlocked, fwd, rflag, cfg_we;
    logic [3:0] grant, refuse, fcode;

    int checks = 0, fails = 0, cycles = 0;
    bit m_key = 0, m_fwd = 0, m_flag = 0;
    logic [3:0] m_grant = 0, m_refuse = 0, m_code = 0;

    always #2 clk = ~clk;

    flash_key_guard i_flash_key_guard (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .cmd_req_i(req), .unlocked_o(unlocked),
        .grant_o(grant), .refuse_o(refuse), .fwd_o(fwd), .fwd_code_o(fcode),
        .refused_flag_o(rflag), .cfg_we_o(cfg_we));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Compare every registered output against the model.
    task automatic cmp_all();
        chk("R2/R3/R4/R7 unlocked", {31'b0, unlocked}, {31'b0, m_key});
        chk("R5 grant", {28'b0, grant}, {28'b0, m_grant});
        chk("R6 refuse", {28'b0, refuse}, {28'b0, m_refuse});
        chk("R8 fwd", {27'b0, fwd, fcode}, {27'b0, m_fwd, m_code});
        chk("R10 refused flag", {31'b0, rflag}, {31'b0, m_flag});
    endtask

    // One bus cycle: drive at negedge, check comb enable, update model at edge.
    task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d, input bit r);
        bit cw;
        @(negedge clk);
        if (rst_n) cmp_all();
        wr = w; addr = a; wdata = d; req = r;
        #1;
        chk("R9 cfg_we", {31'b0, cfg_we}, {31'b0, (w && a == A_CFG && m_key && rst_n)});
        @(posedge clk);
        cycles++;
        if (!rst_n) begin
            m_key = 0; m_grant = 0; m_refuse = 0; m_fwd = 0; m_code = 0; m_flag = 0;
        end else begin
            cw = w && a == A_CMD;
            m_grant = 0; m_refuse = 0; m_fwd = 0; m_code = 0;
            if (cw) begin
                if (d[3:0] >= 1 && d[3:0] <= 4) begin
                    if (m_key) m_grant[d[3:0]-1] = 1'b1;
                    else begin m_refuse[d[3:0]-1] = 1'b1; m_flag = 1; end
                end else begin
                    m_fwd = 1; m_code = d[3:0];
                end
            end else if (w && a == A_STAT && d[0]) m_flag = 0;
            if (cw || r) m_key = 0;
            else if (w && a == A_KEY) m_key = (d == KEYV);
        end
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] lf;
        repeat (3) cyc(0, 0, 0, 0);
        rst_n = 1;
        // R1 reset state
        chk("R1 unlocked after reset", {31'b0, unlocked}, 0);
        chk("R1 flag after reset", {31'b0, rflag}, 0);
        chk("R1 pulses after reset", {23'b0, grant, refuse, fwd}, 0);
        cyc(1, A_CFG, 32'h1, 0);              // R1/R9 locked cfg write
        cyc(1, A_KEY, KEYV, 0);
        chk("R2 unlock", {31'b0, unlocked}, 1);
        cyc(1, A_CFG, 32'h5, 0);              // R9 enable while unlocked
        cyc(1, 8'h30, 32'hFFFF, 0);
        cyc(1, A_STAT, 32'h0, 0);
        cyc(0, 0, 0, 0);
        chk("R4 held", {31'b0, unlocked}, 1);
        cyc(1, A_KEY, KEYV ^ 32'h1, 0);
        chk("R3 wrong key", {31'b0, unlocked}, 0);
        cyc(1, A_KEY, KEYV, 0);
        cyc(1, A_CMD, 32'h1, 0);
        chk("R5 sign granted", {28'b0, grant}, 32'h1);
        chk("R7 cleared by grant", {31'b0, unlocked}, 0);
        cyc(1, A_CMD, 32'h2, 0);
        chk("R6 erase refused", {28'b0, refuse}, 32'h2);
        chk("R6 flag set", {31'b0, rflag}, 1);
        cyc(1, A_KEY, KEYV, 0);
        cyc(1, A_CMD, 32'h9, 0);
        chk("R8 forward code", {27'b0, fwd, fcode}, 32'h19);
        chk("R7 cleared by forward", {31'b0, unlocked}, 0);
        cyc(1, A_CMD, 32'h0, 0);
        chk("R8 forward locked", {31'b0, fwd}, 1);
        cyc(1, A_KEY, KEYV, 0);
        cyc(0, 0, 0, 1);
        chk("R7 request clears", {31'b0, unlocked}, 0);
        cyc(1, A_KEY, KEYV, 1);
        chk("R11 request beats key", {31'b0, unlocked}, 0);
        cyc(1, A_STAT, 32'h2, 0);
        chk("R10 bit0 clear only", {31'b0, rflag}, 1);
        cyc(1, A_STAT, 32'h1, 0);
        chk("R10 flag cleared", {31'b0, rflag}, 0);
        // every code, locked then unlocked (R5, R6, R8)
        for (int c = 0; c < 16; c++) begin
            cyc(1, A_CMD, 32'(c), 0);
            cyc(1, A_KEY, KEYV, 0);
            cyc(1, A_CMD, 32'(c), 0);
        end
        // pseudo-random traffic, model compared every cycle
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1: a = A_KEY;
                3'd2: a = A_CMD;
                3'd3: a = A_CFG;
                3'd4: a = A_STAT;
                default: a = 8'h10 + {4'b0, lf[7:4]};
            endcase
            d = lf[8] ? KEYV : {16'b0, lf};
            if (a == A_CMD) d = {28'b0, lf[11:8]};
            cyc(lf[9] | lf[3], a, d, lf[15:12] == 4'hF);
        end
        cyc(0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule